// File: doc/BRIEF.md
# Two-Mode Interrupt Priority Router

This block gathers interrupt requests from five peripheral sources (two timer/port controllers, an Ethernet controller, a dual-channel serial controller and a non-maskable source) and turns them into a single 3-bit priority level plus an autovector number for a CPU with a 68k-style seven-level interrupt input. How each source maps to a level depends on a mode input that a general-purpose output bit drives. That input can change at any time.

In classic mode the Ethernet request gets no CPU level. It is passed to a separate expansion-slot interrupt line and reaches the CPU through another controller. In alternate mode Ethernet gets its own CPU level, and the slot line is held low. The non-maskable trigger is a single-cycle pulse. A hold timer stretches it into an assertion that lasts a parameterised number of clock cycles. A fresh pulse restarts the hold.

Sources and mode are registered once. The pending register is then loaded from a combinational mapping, so the level output follows a source change two clock edges later.

Top module: `irq_mode_router`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `cpu_ipl` and `cpu_vec` are 0 and `slot_irq` is low.
- R2: A VIA1 request drives `cpu_ipl` = 1 and `cpu_vec` = 25 in both modes. Every nonzero level L is paired with vector 24+L. Outputs reflect inputs sampled two rising edges earlier.
- R3: A VIA2 request maps to level 2 in both modes. A request on either serial channel line (`ser_a_req` or `ser_b_req`) maps to level 4.
- R4: In classic mode (`aux_mode` = 1) an Ethernet request sets `slot_irq` high and produces no CPU level.
- R5: In alternate mode (`aux_mode` = 0) an Ethernet request maps to level 3 (vector 27), and `slot_irq` stays low.
- R6: When several levels are pending, the highest one is presented. Removing it reveals the next highest.
- R7: When no source is asserted, the outputs return to level 0 and vector 0.
- R8: A single-cycle `nmi_trig` pulse makes `cpu_ipl` = 7 (vector 31) for exactly `NMI_HOLD_CYCLES` consecutive cycles. The level then drops.
- R9: A new `nmi_trig` pulse during a hold restarts the hold. Level 7 then lasts from the first pulse until `NMI_HOLD_CYCLES` cycles after the second.
- R10: Changing `aux_mode` while Ethernet is held moves that request between `slot_irq` and level 3 within two edges, and leaves no stale pending state behind.
- R11: Reset cancels a running non-maskable hold. After reset is released, level 7 does not reappear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_mode | input | 1 | Routing mode: 1 classic, 0 alternate |
| via1_req | input | 1 | VIA1 interrupt request level |
| via2_req | input | 1 | VIA2 interrupt request level |
| eth_req | input | 1 | Ethernet interrupt request level |
| ser_a_req | input | 1 | Serial controller channel A request |
| ser_b_req | input | 1 | Serial controller channel B request |
| nmi_trig | input | 1 | Single-cycle non-maskable trigger pulse |
| cpu_ipl | output | 3 | Presented CPU priority level (0 = none) |
| cpu_vec | output | 8 | Autovector number (0 when idle) |
| slot_irq | output | 1 | Expansion-slot interrupt carrying Ethernet in classic mode |

## Verification
The hardest state to reach is a restarted non-maskable hold whose end is observed exactly. A second pulse must land while the first hold is still counting, and the bench must see precisely where the level drops. The bench shortens the hold through the parameter. It fires the second pulse a known ten edges after the first and counts level-7 cycles across the whole window, so an early drop, a missing restart or an off-by-one shows up as a wrong count. A reset is likewise applied in the middle of a hold, and the bench confirms that level 7 never comes back.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   localparam int NUM_SRC  = 5;
   localparam int SRC_VIA1 = 0;
   localparam int SRC_VIA2 = 1;
   localparam int SRC_ETH  = 2;
   localparam int SRC_SER  = 3;
   localparam int SRC_NMI  = 4;

   // CPU level per source; 0 = not routed to the CPU
   function automatic int src_level(int src, bit classic);
      case (src)
         SRC_VIA1: return 1;
         SRC_VIA2: return 2;
         SRC_ETH:  return classic ? 0 : 3;
         SRC_SER:  return 4;
         SRC_NMI:  return 7;
         default:  return 0;
      endcase
   endfunction

   // which sources land on a given CPU level
   function automatic logic [NUM_SRC-1:0] src_mask(int lvl, bit classic);
      logic [NUM_SRC-1:0] m;
      m = '0;
      for (int s = 0; s < NUM_SRC; s++)
         if (src_level(s, classic) == lvl) m[s] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/irq_input_stage.sv
module irq_input_stage
   import irq_router_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic aux_mode,
   input  logic via1_req,
   input  logic via2_req,
   input  logic eth_req,
   input  logic ser_a_req,
   input  logic ser_b_req,
   output logic classic_q,
   output logic via1_q,
   output logic via2_q,
   output logic eth_q,
   output logic ser_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         classic_q <= 1'b0;
         via1_q    <= 1'b0;
         via2_q    <= 1'b0;
         eth_q     <= 1'b0;
         ser_q     <= 1'b0;
      end else begin
         classic_q <= aux_mode;
         via1_q    <= via1_req;
         via2_q    <= via2_req;
         eth_q     <= eth_req;
         ser_q     <= ser_a_req | ser_b_req;
      end
   end
endmodule

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
   parameter int HOLD_CYCLES = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);
   localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         active <= 1'b0;
      end else if (trig) begin
         remain <= CNT_W'(HOLD_CYCLES);
         active <= 1'b1;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
         active <= (remain != CNT_W'(1));
      end
   end
endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
   import irq_router_pkg::*;
#(
   parameter int PEND_W = 8
) (
   input  logic [NUM_SRC-1:0] src,
   input  logic               classic,
   output logic [PEND_W-1:0]  pend_next,
   output logic               slot_next
);
   for (genvar b = 0; b < PEND_W; b++) begin : g_bit
      localparam logic [NUM_SRC-1:0] M_CL = src_mask(b + 1, 1'b1);
      localparam logic [NUM_SRC-1:0] M_AL = src_mask(b + 1, 1'b0);
      assign pend_next[b] = |(src & (classic ? M_CL : M_AL));
   end

   assign slot_next = classic & src[SRC_ETH];
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan #(
   parameter int PEND_W   = 8,
   parameter int LEVEL_W  = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 24
) (
   input  logic [PEND_W-1:0]  pend,
   output logic [LEVEL_W-1:0] level,
   output logic [VEC_W-1:0]   vector
);
   // ascending walk: the last hit is the highest set bit
   always_comb begin
      level  = '0;
      vector = '0;
      for (int i = 0; i < PEND_W; i++) begin
         if (pend[i]) begin
            level  = LEVEL_W'(i + 1);
            vector = VEC_W'(VEC_BASE + i + 1);
         end
      end
   end
endmodule

// File: rtl/irq_mode_router.sv
module irq_mode_router
   import irq_router_pkg::*;
#(
   parameter int LEVEL_W         = 3,
   parameter int VEC_W           = 8,
   parameter int VEC_BASE        = 24,
   parameter int NMI_HOLD_CYCLES = 25_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               aux_mode,
   input  logic               via1_req,
   input  logic               via2_req,
   input  logic               eth_req,
   input  logic               ser_a_req,
   input  logic               ser_b_req,
   input  logic               nmi_trig,
   output logic [LEVEL_W-1:0] cpu_ipl,
   output logic [VEC_W-1:0]   cpu_vec,
   output logic               slot_irq
);
   localparam int PEND_W = 1 << LEVEL_W;

   if (NMI_HOLD_CYCLES < 1) begin : g_bad_hold
      $error("NMI_HOLD_CYCLES must be at least 1");
   end
   if (LEVEL_W != 3) begin : g_bad_level
      $error("LEVEL_W must be 3 for a seven-level CPU");
   end
   if (VEC_BASE + PEND_W >= (1 << VEC_W)) begin : g_bad_vec
      $error("VEC_BASE plus levels exceeds VEC_W");
   end

   logic classic_q, via1_q, via2_q, eth_q, ser_q, nmi_act;
   logic [NUM_SRC-1:0] src_vec;
   logic [PEND_W-1:0]  pend_next, pend_q;
   logic               slot_next;

   irq_input_stage u_in (
      .clk(clk), .rst_n(rst_n), .aux_mode(aux_mode),
      .via1_req(via1_req), .via2_req(via2_req), .eth_req(eth_req),
      .ser_a_req(ser_a_req), .ser_b_req(ser_b_req),
      .classic_q(classic_q), .via1_q(via1_q), .via2_q(via2_q),
      .eth_q(eth_q), .ser_q(ser_q)
   );

   irq_nmi_stretch #(.HOLD_CYCLES(NMI_HOLD_CYCLES)) u_nmi (
      .clk(clk), .rst_n(rst_n), .trig(nmi_trig), .active(nmi_act)
   );

   always_comb begin
      src_vec           = '0;
      src_vec[SRC_VIA1] = via1_q;
      src_vec[SRC_VIA2] = via2_q;
      src_vec[SRC_ETH]  = eth_q;
      src_vec[SRC_SER]  = ser_q;
      src_vec[SRC_NMI]  = nmi_act;
   end

   irq_level_map #(.PEND_W(PEND_W)) u_map (
      .src(src_vec), .classic(classic_q),
      .pend_next(pend_next), .slot_next(slot_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q   <= '0;
         slot_irq <= 1'b0;
      end else begin
         pend_q   <= pend_next;
         slot_irq <= slot_next;
      end
   end

   irq_prio_scan #(
      .PEND_W(PEND_W), .LEVEL_W(LEVEL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
   ) u_scan (
      .pend(pend_q), .level(cpu_ipl), .vector(cpu_vec)
   );
endmodule

// File: rtl/irq_mode_router_chk.sv
module irq_mode_router_chk #(
   parameter int LEVEL_W  = 3,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic               aux_mode,
   input logic               via1_req,
   input logic               eth_req,
   input logic               nmi_trig,
   input logic [LEVEL_W-1:0] cpu_ipl,
   input logic [VEC_W-1:0]   cpu_vec,
   input logic               slot_irq
);
   logic [1:0] since_rst;
   logic       warm;

   always_ff @(posedge clk) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
   end
   assign warm = (since_rst >= 2'd2);

   assert_vec_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ipl != '0) |-> (cpu_vec == VEC_W'(VEC_BASE) + VEC_W'(cpu_ipl)));

   assert_idle_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ipl == '0) |-> (cpu_vec == '0));

   assert_via1_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(via1_req, 2)) |-> (cpu_ipl != '0));

   assert_eth_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(aux_mode, 2) && $past(eth_req, 2)) |-> (slot_irq && cpu_ipl != LEVEL_W'(3)));

   assert_slot_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(aux_mode, 2)) |-> !slot_irq);

   assert_nmi_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(nmi_trig, 2)) |-> (cpu_ipl == LEVEL_W'(7)));
endmodule

bind irq_mode_router irq_mode_router_chk #(
   .LEVEL_W(LEVEL_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .aux_mode(aux_mode), .via1_req(via1_req),
   .eth_req(eth_req), .nmi_trig(nmi_trig), .cpu_ipl(cpu_ipl),
   .cpu_vec(cpu_vec), .slot_irq(slot_irq)
);

// File: tb/irq_mode_router_bench.sv
module irq_mode_router_bench;
   localparam int HOLD = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       aux_mode = 1'b1;
   logic       via1_req = 1'b0, via2_req = 1'b0, eth_req = 1'b0;
   logic       ser_a_req = 1'b0, ser_b_req = 1'b0, nmi_trig = 1'b0;
   logic [2:0] cpu_ipl;
   logic [7:0] cpu_vec;
   logic       slot_irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_mode_router #(.NMI_HOLD_CYCLES(HOLD)) u_irq_mode_router (
      .clk(clk), .rst_n(rst_n), .aux_mode(aux_mode),
      .via1_req(via1_req), .via2_req(via2_req), .eth_req(eth_req),
      .ser_a_req(ser_a_req), .ser_b_req(ser_b_req), .nmi_trig(nmi_trig),
      .cpu_ipl(cpu_ipl), .cpu_vec(cpu_vec), .slot_irq(slot_irq)
   );

   task automatic check_out(string req, int lvl, int vec, bit slot);
      n_run++;
      if (cpu_ipl != 3'(lvl) || cpu_vec != 8'(vec) || slot_irq != slot) begin
         n_fail++;
         $display("FAIL %s: got ipl=%0d vec=%0d slot=%0b, expected ipl=%0d vec=%0d slot=%0b",
                  req, cpu_ipl, cpu_vec, slot_irq, lvl, vec, slot);
      end
   endtask

   task automatic check_int(string req, int got, int exp);
      n_run++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d, expected %0d", req, got, exp);
      end
   endtask

   // drive at a falling edge, then settle across two rising edges
   task automatic apply(bit mode, bit v1, bit v2, bit e, bit sa, bit sb);
      @(negedge clk);
      aux_mode = mode; via1_req = v1; via2_req = v2; eth_req = e;
      ser_a_req = sa; ser_b_req = sb;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_nmi();
      @(negedge clk); nmi_trig = 1'b1;
      @(negedge clk); nmi_trig = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_out("R1 in reset", 0, 0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 after release", 0, 0, 1'b0);
   endtask

   task automatic t_basic();
      apply(1, 1, 0, 0, 0, 0); check_out("R2 via1 classic", 1, 25, 1'b0);
      apply(0, 1, 0, 0, 0, 0); check_out("R2 via1 alternate", 1, 25, 1'b0);
      apply(1, 0, 1, 0, 0, 0); check_out("R3 via2", 2, 26, 1'b0);
      apply(1, 0, 0, 0, 1, 0); check_out("R3 serial A", 4, 28, 1'b0);
      apply(0, 0, 0, 0, 0, 1); check_out("R3 serial B", 4, 28, 1'b0);
      apply(1, 0, 0, 0, 0, 0); check_out("R7 idle", 0, 0, 1'b0);
   endtask

   task automatic t_eth_modes();
      apply(1, 0, 0, 1, 0, 0); check_out("R4 eth classic", 0, 0, 1'b1);
      apply(0, 0, 0, 1, 0, 0); check_out("R5 eth alternate", 3, 27, 1'b0);
      // R10: flip mode only, eth held
      apply(1, 0, 0, 1, 0, 0); check_out("R10 back to classic", 0, 0, 1'b1);
      apply(1, 1, 0, 1, 0, 0); check_out("R10 classic with via1", 1, 25, 1'b1);
      apply(0, 1, 0, 1, 0, 0); check_out("R10 alternate with via1", 3, 27, 1'b0);
      apply(0, 0, 0, 0, 0, 0); check_out("R7 idle alt", 0, 0, 1'b0);
   endtask

   task automatic t_priority();
      apply(0, 1, 1, 1, 1, 0); check_out("R6 all pending", 4, 28, 1'b0);
      apply(0, 1, 1, 1, 0, 0); check_out("R6 drop serial", 3, 27, 1'b0);
      apply(0, 1, 1, 0, 0, 0); check_out("R6 drop eth", 2, 26, 1'b0);
      apply(0, 1, 0, 0, 0, 0); check_out("R6 drop via2", 1, 25, 1'b0);
      apply(1, 0, 0, 0, 0, 0); check_out("R7 all clear", 0, 0, 1'b0);
   endtask

   task automatic t_nmi_single();
      int n7 = 0;
      apply(1, 1, 0, 0, 1, 0);
      pulse_nmi();
      for (int i = 0; i < HOLD + 10; i++) begin
         @(negedge clk);
         if (cpu_ipl == 3'd7) begin
            n7++;
            if (n7 == 1) check_out("R8 nmi level", 7, 31, 1'b0);
         end
      end
      check_int("R8 nmi hold length", n7, HOLD);
      check_out("R8 after hold", 4, 28, 1'b0);
      apply(1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_nmi_restart();
      int n7 = 0;
      pulse_nmi();
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (cpu_ipl == 3'd7) n7++;
      end
      nmi_trig = 1'b1;
      for (int i = 0; i < HOLD + 30; i++) begin
         @(negedge clk);
         if (i == 0) nmi_trig = 1'b0;
         if (cpu_ipl == 3'd7) n7++;
      end
      check_int("R9 restarted hold length", n7, HOLD + 10);
   endtask

   task automatic t_reset_cancel();
      int n7 = 0;
      pulse_nmi();
      repeat (3) @(negedge clk);
      check_out("R11 nmi running", 7, 31, 1'b0);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < HOLD + 10; i++) begin
         @(negedge clk);
         if (cpu_ipl == 3'd7) n7++;
      end
      check_int("R11 level 7 after reset", n7, 0);
      check_out("R11 idle after reset", 0, 0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_eth_modes();
      t_priority();
      t_nmi_single();
      t_nmi_restart();
      t_reset_cancel();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule